// File: doc/BRIEF.md
# Event-Based Branch Delivery Unit

This unit sits next to the fetch logic of a simple processor core. It delivers event-based branches that run at user level. A one-cycle request from upstream event logic arms a pending flag. The flag stays armed until two things hold at once: the core runs in user state, and the global-enable bit of the branch status register is set. An event that arrives during supervisor code is therefore postponed, not lost.

In the cycle that delivery is allowed, the unit reads the two "event occurred" flags in the status register to choose the exception kind. The performance-monitor flag has priority over the external flag. In that same cycle it raises three strobes together:
- a fetch redirect, whose target is the handler register value;
- a write of the current next-instruction address into the return register;
- a write of the status register with global enable cleared.

The machine state register is not touched, and there is no fixed vector address. The facility-enable check and the per-event qualifying bits are handled upstream.

Top module: `ebb_delivery_unit`

## Requirements
- R1: An active-low reset clears the pending flag. While reset is asserted, and after it is released with no request since, no strobe is raised and the exception code is 0.
- R2: A pending event is not delivered, and stays pending, while user_mode_i is 0 or the global-enable bit (stat_i bit 31) is 0.
- R3: When an event is pending, user_mode_i is 1 and stat_i bit 31 is 1, redirect_o, ret_we_o and stat_we_o rise together in that cycle, provided an occurred flag is set.
- R4: On delivery with the performance-monitor occurred flag (stat_i bit 0) set, exc_code_o is 103, whatever the external flag holds.
- R5: On delivery with only the external occurred flag (stat_i bit 2) set, exc_code_o is 104.
- R6: On delivery, stat_wdata_o equals stat_i with bit 31 cleared and every other bit unchanged.
- R7: On delivery, ret_data_o equals nia_i and target_o equals handler_i.
- R8: A delivery clears the pending flag, so the strobes last one cycle when no new request arrives.
- R9: If the delivery conditions hold but neither occurred flag is set, the pending flag is cleared and no strobe is raised. A later setting of a flag does not produce a delivery.
- R10: A request that arrives in a delivery cycle re-arms the pending flag, which gives a second delivery in the next cycle if the conditions still hold.
- R11: exc_code_o is 0 in every cycle without a redirect.
- R12: With no request, user state and global enable alone raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_req_i | input | 1 | One-cycle event request |
| user_mode_i | input | 1 | 1 when the core runs in user state |
| stat_i | input | STAT_W | Current branch status register |
| handler_i | input | ADDR_W | Handler address register |
| nia_i | input | ADDR_W | Current next-instruction address |
| redirect_o | output | 1 | Fetch redirect strobe |
| target_o | output | ADDR_W | Redirect target |
| ret_we_o | output | 1 | Return register write strobe |
| ret_data_o | output | ADDR_W | Return register write data |
| stat_we_o | output | 1 | Status register write strobe |
| stat_wdata_o | output | STAT_W | Status register write data |
| exc_code_o | output | 8 | Exception code: 103 perf-monitor, 104 external, 0 idle |

## Verification
The hardest situation to reach is a request that coincides with a delivery. The pending flag must be cleared and set again by the same edge. The bench holds user state and global enable high while it pulses a request. It then pulses a second request exactly in the cycle in which the strobes are up, and it expects one more delivery in the next cycle followed by silence. The case with no occurred flag is also reached only indirectly: the bench lets delivery conditions pass with both flags low, then raises a flag and checks that nothing is delivered.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
  localparam int unsigned CODE_W = 8;

  typedef enum logic [CODE_W-1:0] {
    EXC_NONE    = 8'd0,
    EXC_PM_EBB  = 8'd103,
    EXC_EXT_EBB = 8'd104
  } ebb_exc_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_PM   = 2'd1,
    KIND_EXT  = 2'd2
  } ebb_kind_e;

  function automatic ebb_exc_e kind_to_code(ebb_kind_e k);
    case (k)
      KIND_PM:  return EXC_PM_EBB;
      KIND_EXT: return EXC_EXT_EBB;
      default:  return EXC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ebb_rst_sync.sv
module ebb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ebb_pend_latch.sv
module ebb_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  // A take clears the flag unless a new request arrives in the same cycle.
  always_comb begin
    pend_en = set_i | take_i;
    pend_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ebb_take_gate.sv
module ebb_take_gate
  import ebb_pkg::*;
(
  input  logic      pend_i,
  input  logic      user_i,
  input  logic      ge_i,
  input  logic      pm_occ_i,
  input  logic      ext_occ_i,
  output logic      take_o,
  output ebb_kind_e kind_o
);
  always_comb begin
    take_o = pend_i & user_i & ge_i;
    kind_o = KIND_NONE;
    if (take_o) begin
      if (pm_occ_i)       kind_o = KIND_PM;
      else if (ext_occ_i) kind_o = KIND_EXT;
    end
  end
endmodule

// File: rtl/ebb_commit.sv
module ebb_commit
  import ebb_pkg::*;
#(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned GE_BIT = 31
) (
  input  ebb_kind_e          kind_i,
  input  logic [STAT_W-1:0]  stat_i,
  input  logic [ADDR_W-1:0]  handler_i,
  input  logic [ADDR_W-1:0]  nia_i,
  output logic               fire_o,
  output logic [ADDR_W-1:0]  target_o,
  output logic [ADDR_W-1:0]  ret_data_o,
  output logic [STAT_W-1:0]  stat_wdata_o,
  output logic [CODE_W-1:0]  code_o
);
  localparam logic [STAT_W-1:0] GE_MASK = STAT_W'(1) << GE_BIT;

  always_comb begin
    fire_o       = (kind_i != KIND_NONE);
    target_o     = handler_i;
    ret_data_o   = nia_i;
    stat_wdata_o = stat_i & ~GE_MASK;
    code_o       = kind_to_code(kind_i);
  end
endmodule

// File: rtl/ebb_delivery_unit.sv
module ebb_delivery_unit
  import ebb_pkg::*;
#(
  parameter int unsigned STAT_W  = 32,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned GE_BIT  = 31,
  parameter int unsigned PMO_BIT = 0,
  parameter int unsigned EXO_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_req_i,
  input  logic              user_mode_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [ADDR_W-1:0] handler_i,
  input  logic [ADDR_W-1:0] nia_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              ret_we_o,
  output logic [ADDR_W-1:0] ret_data_o,
  output logic              stat_we_o,
  output logic [STAT_W-1:0] stat_wdata_o,
  output logic [7:0]        exc_code_o
);
  logic      rst_sync_n;
  logic      pend;
  logic      take;
  logic      fire;
  ebb_kind_e kind;

  ebb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ebb_pend_latch u_pend (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(evt_req_i), .take_i(take), .pend_o(pend)
  );

  ebb_take_gate u_gate (
    .pend_i(pend), .user_i(user_mode_i), .ge_i(stat_i[GE_BIT]),
    .pm_occ_i(stat_i[PMO_BIT]), .ext_occ_i(stat_i[EXO_BIT]),
    .take_o(take), .kind_o(kind)
  );

  ebb_commit #(.STAT_W(STAT_W), .ADDR_W(ADDR_W), .GE_BIT(GE_BIT)) u_commit (
    .kind_i(kind), .stat_i(stat_i), .handler_i(handler_i), .nia_i(nia_i),
    .fire_o(fire), .target_o(target_o), .ret_data_o(ret_data_o),
    .stat_wdata_o(stat_wdata_o), .code_o(exc_code_o)
  );

  assign redirect_o = fire;
  assign ret_we_o   = fire;
  assign stat_we_o  = fire;
endmodule

// File: rtl/ebb_delivery_chk.sv
module ebb_delivery_chk #(
  parameter int unsigned STAT_W  = 32,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned GE_BIT  = 31,
  parameter int unsigned PMO_BIT = 0,
  parameter int unsigned EXO_BIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_req_i,
  input logic              user_mode_i,
  input logic [STAT_W-1:0] stat_i,
  input logic [ADDR_W-1:0] handler_i,
  input logic [ADDR_W-1:0] nia_i,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] target_o,
  input logic              ret_we_o,
  input logic [ADDR_W-1:0] ret_data_o,
  input logic              stat_we_o,
  input logic [STAT_W-1:0] stat_wdata_o,
  input logic [7:0]        exc_code_o
);
  localparam logic [STAT_W-1:0] GE_M = STAT_W'(1) << GE_BIT;

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (user_mode_i && stat_i[GE_BIT]));
  p_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o == ret_we_o) && (redirect_o == stat_we_o));
  p_pm_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && stat_i[PMO_BIT]) |-> exc_code_o == 8'd103);
  p_ext_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !stat_i[PMO_BIT] && stat_i[EXO_BIT]) |-> exc_code_o == 8'd104);
  p_stat_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we_o |-> (!stat_wdata_o[GE_BIT] &&
                   ((stat_wdata_o | GE_M) == (stat_i | GE_M))));
  p_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (target_o == handler_i && ret_data_o == nia_i));
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !evt_req_i) |=> !redirect_o);
  p_idle_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> exc_code_o == 8'd0);
endmodule

bind ebb_delivery_unit ebb_delivery_chk #(
  .STAT_W(STAT_W), .ADDR_W(ADDR_W), .GE_BIT(GE_BIT),
  .PMO_BIT(PMO_BIT), .EXO_BIT(EXO_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_req_i(evt_req_i), .user_mode_i(user_mode_i),
  .stat_i(stat_i), .handler_i(handler_i), .nia_i(nia_i),
  .redirect_o(redirect_o), .target_o(target_o), .ret_we_o(ret_we_o),
  .ret_data_o(ret_data_o), .stat_we_o(stat_we_o),
  .stat_wdata_o(stat_wdata_o), .exc_code_o(exc_code_o)
);

// File: tb/ebb_delivery_unit_tb_top.sv
module ebb_delivery_unit_tb_top;
  localparam int STAT_W = 32;
  localparam int ADDR_W = 64;
  localparam logic [STAT_W-1:0] GE  = 32'h8000_0000;
  localparam logic [STAT_W-1:0] PMO = 32'h0000_0001;
  localparam logic [STAT_W-1:0] EXO = 32'h0000_0004;
  localparam logic [STAT_W-1:0] XTRA = 32'h0012_3400;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              evt_req_i;
  logic              user_mode_i;
  logic [STAT_W-1:0] stat_i;
  logic [ADDR_W-1:0] handler_i;
  logic [ADDR_W-1:0] nia_i;
  logic              redirect_o;
  logic [ADDR_W-1:0] target_o;
  logic              ret_we_o;
  logic [ADDR_W-1:0] ret_data_o;
  logic              stat_we_o;
  logic [STAT_W-1:0] stat_wdata_o;
  logic [7:0]        exc_code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ebb_delivery_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_req_i(evt_req_i), .user_mode_i(user_mode_i),
    .stat_i(stat_i), .handler_i(handler_i), .nia_i(nia_i),
    .redirect_o(redirect_o), .target_o(target_o), .ret_we_o(ret_we_o),
    .ret_data_o(ret_data_o), .stat_we_o(stat_we_o),
    .stat_wdata_o(stat_wdata_o), .exc_code_o(exc_code_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Move to the next falling edge, apply inputs there, then settle.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_idle(string req);
    #1;
    check(req, {61'd0, redirect_o, ret_we_o, stat_we_o}, 64'd0);
    check(req, exc_code_o, 64'd0);
  endtask

  task automatic expect_deliver(string req, logic [7:0] code);
    #1;
    check(req, {61'd0, redirect_o, ret_we_o, stat_we_o}, 64'd7);
    check(req, exc_code_o, code);
    check(req, stat_wdata_o, stat_i & ~GE);
    check(req, ret_data_o, nia_i);
    check(req, target_o, handler_i);
  endtask

  task automatic pulse_req();
    step(); evt_req_i = 1'b1;
    step(); evt_req_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    expect_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_reset_idle();
    user_mode_i = 1'b1; stat_i = GE | PMO;
    do_reset();
    expect_idle("R1 after release");
    repeat (3) begin step(); expect_idle("R12 no request"); end
  endtask

  task automatic t_hold_and_pm();
    user_mode_i = 1'b0; stat_i = GE | PMO | XTRA;
    pulse_req();
    repeat (3) begin expect_idle("R2 supervisor"); step(); end
    user_mode_i = 1'b1; stat_i = PMO | XTRA;
    expect_idle("R2 ge low");
    step();
    stat_i = GE | PMO | XTRA; nia_i = 64'h0000_1000_2000_3004;
    handler_i = 64'h0000_7fff_0000_0100;
    expect_deliver("R3 R4 R6 R7 pm", 8'd103);
    step();
    expect_idle("R8 single cycle");
  endtask

  task automatic t_ext();
    user_mode_i = 1'b1; stat_i = GE | EXO; nia_i = 64'h44; handler_i = 64'h9000;
    step(); evt_req_i = 1'b1;
    step(); evt_req_i = 1'b0;
    expect_deliver("R5 external", 8'd104);
    step(); expect_idle("R8 after ext");
  endtask

  task automatic t_both();
    stat_i = GE | PMO | EXO | XTRA;
    pulse_req();
    expect_deliver("R4 priority", 8'd103);
    step(); expect_idle("R8 after both");
  endtask

  task automatic t_none();
    stat_i = GE;
    pulse_req();
    expect_idle("R9 no flag");
    step(); stat_i = GE | PMO;
    expect_idle("R9 flag later");
  endtask

  task automatic t_rearm();
    stat_i = GE | EXO; nia_i = 64'h500; handler_i = 64'h600;
    pulse_req();
    expect_deliver("R10 first", 8'd104);
    evt_req_i = 1'b1;
    step(); evt_req_i = 1'b0;
    nia_i = 64'h504;
    expect_deliver("R10 second", 8'd104);
    step(); expect_idle("R10 then quiet");
  endtask

  task automatic t_reset_clears();
    user_mode_i = 1'b0; stat_i = GE | PMO;
    pulse_req();
    do_reset();
    user_mode_i = 1'b1;
    expect_idle("R1 pending dropped");
    step(); expect_idle("R1 pending dropped 2");
  endtask

  initial begin
    rst_n = 1'b0; evt_req_i = 1'b0; user_mode_i = 1'b0;
    stat_i = '0; handler_i = '0; nia_i = '0;
    t_reset_idle();
    t_hold_and_pm();
    t_ext();
    t_both();
    t_none();
    t_rearm();
    t_reset_clears();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule